// File: doc/BRIEF.md
# Boot-Mode Entry and Autobaud Detector

This block decides whether the device starts up in program-load configuration. The load configuration is entered when the reset input is high and the program-store-enable input is low at the same clock edge. From then on, two selector pins choose one of two paths. On the parallel path the block waits for a load strobe and then raises a parallel-load flag. On the serial path it waits for one synchronisation character, a carriage return (0x0D).

On the serial path the block times the low start bit of the incoming character. It compares that width with four windows, one for each supported rate: 300, 1200, 2400 and 9600 bit/s. When a window matches, the block samples the rest of the frame at that rate as 8N1. It locks only if the decoded byte and the stop bit are correct. A downstream UART then takes the 2-bit rate code and the clocks-per-bit divisor. Both values stay frozen until reset is released. Releasing reset at any time returns the block to idle.

All inputs except the receive line are taken as synchronous to `clk`. The receive line passes through a two-stage synchroniser. The parameter `SLOW_BIT` is the number of clocks per bit at 300 bit/s. The other rates use that value divided by 4, 8 and 32.

Top module: `bootbaud_top`

## Requirements
- R1: `loadMode` goes to 1 one clock after an edge at which `rstHold`=1 and `psenN`=0 together. Neither input alone moves the block out of idle.
- R2: An edge with `rstHold`=0 clears `loadMode`, `parLoad`, `locked`, `rateCode` and `divisor` to 0 by the next clock, whatever the block was doing.
- R3: In load mode with `selHi` other than 2'b11, a `loadPulse` sets `parLoad` the next clock. On this path the serial line is ignored, so `locked` stays 0. `parLoad` and `locked` are never 1 together.
- R4: In load mode with `selHi`=2'b11 (both upper selector pins high), only the serial path is active and `loadPulse` has no effect on `parLoad`.
- R5: A start-bit low width W, in clocks, selects rate code c when LEN(c)-LEN(c)/10 <= W <= LEN(c)+LEN(c)/10 (integer division). The lengths are LEN(0)=SLOW_BIT (300 bit/s), LEN(1)=SLOW_BIT/4 (1200), LEN(2)=SLOW_BIT/8 (2400) and LEN(3)=SLOW_BIT/32 (9600).
- R6: A start-bit width outside every window gives no lock, and the block goes back to waiting. A later well-formed character at a supported rate still locks.
- R7: After a window matches, the block samples the eight data bits LSB first, each in the middle of its bit, and then the stop bit. It locks only if the byte is 0x0D and the stop bit is 1. Otherwise it goes back to waiting.
- R8: When locked, `rateCode` is the matched code and `divisor` equals LEN of that code. Both, and `locked` itself, stay fixed while `rstHold` stays 1, even if more characters or load pulses arrive.
- R9: `rateCode` and `divisor` read 0 whenever `locked` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstHold | input | 1 | Reset pin level; 1 holds the device in reset, 0 returns this block to idle |
| psenN | input | 1 | Program-store-enable pin, active low |
| selHi | input | 2 | Upper two port-2 selector pins, {bit7, bit6} |
| loadPulse | input | 1 | Parallel load strobe, one clock wide |
| rxIn | input | 1 | Asynchronous serial receive line, idle high |
| loadMode | output | 1 | Block is in program-load configuration |
| parLoad | output | 1 | Parallel load cycle accepted |
| locked | output | 1 | Serial rate found and synchronisation character confirmed |
| rateCode | output | 2 | Matched rate code (0=300, 1=1200, 2=2400, 3=9600), 0 when not locked |
| divisor | output | DIVW | Clocks per bit at the matched rate, 0 when not locked |

## Verification
A load strobe and the falling start edge of a serial character can arrive in the same clock. The bench drives both on the same clock edge, once with the serial selection and once with a parallel selection. With the serial selection the strobe must be ignored and the character must still lock. With a parallel selection the strobe must win and the character must leave `locked` at 0. The rate windows are swept at five start-bit widths per rate, on both sides of every edge. The expected code comes from the window arithmetic in R5.

// File: rtl/bootbaud_pkg.sv
package bootbaud_pkg;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic startMeas;   // falling start edge seen: begin timing
    logic countLow;    // line still low: keep timing
    logic armSample;   // rate matched: preload half-bit offset
    logic stepSample;  // advance the bit sampler
    logic latchRate;   // capture rate code and divisor
  } ctrlStrb_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_WAIT, ST_MEAS, ST_SAMP, ST_CHECK, ST_LOCK, ST_PAR
  } bootState_t;

  // Clocks per bit for a rate code, given clocks per bit at the slowest rate
  function automatic int unsigned rateLen(int unsigned slowBit, logic [1:0] code);
    case (code)
      2'd0:    return slowBit;
      2'd1:    return slowBit >> 2;
      2'd2:    return slowBit >> 3;
      default: return slowBit >> 5;
    endcase
  endfunction

endpackage

// File: rtl/autobaud_datapath.sv
module autobaud_datapath
  import bootbaud_pkg::*;
#(
  parameter int unsigned SLOW_BIT = 36864,
  parameter int unsigned DIVW     = $clog2(SLOW_BIT + 1)
) (
  input  logic            clk,
  input  logic            clr,
  input  logic            rxIn,
  input  ctrlStrb_t       strb,
  output logic            rxLow,
  output logic            rxFell,
  output logic            hitAny,
  output logic            lastSample,
  output logic            frameOk,
  output logic [1:0]      rateReg,
  output logic [DIVW-1:0] divReg
);

  localparam int unsigned CNT_MAX = SLOW_BIT + SLOW_BIT / 10 + 1;
  localparam int unsigned CW      = $clog2(CNT_MAX + 1);

  logic          rxMeta, rxSync, rxPrev;
  logic [CW-1:0] cnt;
  logic [3:0]    hitVec;
  logic [1:0]    hitCode;
  logic [CW-1:0] hitLen, armVal;
  logic          sampleNow;
  logic [3:0]    bitIdx;
  logic [7:0]    shiftReg;
  logic          stopBit;

  // Two-stage synchroniser plus edge history; idles high
  always_ff @(posedge clk) begin
    if (clr) begin
      rxMeta <= 1'b1;
      rxSync <= 1'b1;
      rxPrev <= 1'b1;
    end else begin
      rxMeta <= rxIn;
      rxSync <= rxMeta;
      rxPrev <= rxSync;
    end
  end

  assign rxLow  = !rxSync;
  assign rxFell = rxPrev && !rxSync;

  // One tolerance window per supported rate
  for (genvar g = 0; g < 4; g++) begin : g_win
    localparam int unsigned LEN = rateLen(SLOW_BIT, 2'(g));
    localparam int unsigned LO  = LEN - LEN / 10;
    localparam int unsigned HI  = LEN + LEN / 10;
    assign hitVec[g] = (cnt >= CW'(LO)) && (cnt <= CW'(HI));
  end

  always_comb begin
    hitCode = 2'd0;
    for (int i = 0; i < 4; i++)
      if (hitVec[i]) hitCode = 2'(i);
  end

  assign hitAny = |hitVec;
  assign hitLen = CW'(rateLen(SLOW_BIT, hitCode));
  assign armVal = hitLen - (hitLen >> 1);

  assign sampleNow  = strb.stepSample && (cnt == CW'(divReg));
  assign lastSample = sampleNow && (bitIdx == 4'd8);

  // Shared counter: start-bit width first, then bit-period timer
  always_ff @(posedge clk) begin
    if (clr)                  cnt <= '0;
    else if (strb.startMeas)  cnt <= CW'(1);
    else if (strb.countLow) begin
      if (cnt != CW'(CNT_MAX)) cnt <= cnt + 1'b1;
    end
    else if (strb.armSample)  cnt <= armVal;
    else if (strb.stepSample) cnt <= sampleNow ? CW'(1) : cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      rateReg <= '0;
      divReg  <= '0;
    end else if (strb.latchRate) begin
      rateReg <= hitCode;
      divReg  <= DIVW'(rateLen(SLOW_BIT, hitCode));
    end
  end

  // LSB-first data shifter, then stop-bit capture
  always_ff @(posedge clk) begin
    if (clr || strb.armSample) begin
      bitIdx   <= '0;
      shiftReg <= '0;
      stopBit  <= 1'b0;
    end else if (sampleNow) begin
      bitIdx <= bitIdx + 1'b1;
      if (bitIdx == 4'd8) stopBit  <= rxSync;
      else                shiftReg <= {rxSync, shiftReg[7:1]};
    end
  end

  assign frameOk = (shiftReg == 8'h0D) && stopBit;

endmodule

// File: rtl/bootbaud_ctrl.sv
module bootbaud_ctrl
  import bootbaud_pkg::*;
(
  input  logic       clk,
  input  logic       rstHold,
  input  logic       psenN,
  input  logic [1:0] selHi,
  input  logic       loadPulse,
  input  logic       rxLow,
  input  logic       rxFell,
  input  logic       hitAny,
  input  logic       lastSample,
  input  logic       frameOk,
  output ctrlStrb_t  strb,
  output logic       loadMode,
  output logic       parLoad,
  output logic       locked
);

  bootState_t state, nextState;
  logic       serialSel;

  assign serialSel = (selHi == 2'b11);

  always_comb begin
    nextState = state;
    strb      = '0;
    case (state)
      ST_IDLE:  if (!psenN) nextState = ST_WAIT;
      ST_WAIT: begin
        if (serialSel) begin
          if (rxFell) begin
            strb.startMeas = 1'b1;
            nextState      = ST_MEAS;
          end
        end else if (loadPulse) begin
          nextState = ST_PAR;
        end
      end
      ST_MEAS: begin
        if (rxLow) begin
          strb.countLow = 1'b1;
        end else if (hitAny) begin
          strb.latchRate = 1'b1;
          strb.armSample = 1'b1;
          nextState      = ST_SAMP;
        end else begin
          nextState = ST_WAIT;
        end
      end
      ST_SAMP: begin
        strb.stepSample = 1'b1;
        if (lastSample) nextState = ST_CHECK;
      end
      ST_CHECK: nextState = frameOk ? ST_LOCK : ST_WAIT;
      default:  nextState = state;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstHold) state <= ST_IDLE;
    else          state <= nextState;
  end

  assign loadMode = (state != ST_IDLE);
  assign parLoad  = (state == ST_PAR);
  assign locked   = (state == ST_LOCK);

endmodule

// File: rtl/bootbaud_top.sv
module bootbaud_top
  import bootbaud_pkg::*;
#(
  parameter int unsigned SLOW_BIT = 36864,
  parameter int unsigned DIVW     = $clog2(SLOW_BIT + 1)
) (
  input  logic            clk,
  input  logic            rstHold,
  input  logic            psenN,
  input  logic [1:0]      selHi,
  input  logic            loadPulse,
  input  logic            rxIn,
  output logic            loadMode,
  output logic            parLoad,
  output logic            locked,
  output logic [1:0]      rateCode,
  output logic [DIVW-1:0] divisor
);

  ctrlStrb_t       strb;
  logic            rxLow, rxFell, hitAny, lastSample, frameOk;
  logic [1:0]      rateReg;
  logic [DIVW-1:0] divReg;

  bootbaud_ctrl u_ctrl (
    .clk(clk), .rstHold(rstHold), .psenN(psenN), .selHi(selHi),
    .loadPulse(loadPulse), .rxLow(rxLow), .rxFell(rxFell), .hitAny(hitAny),
    .lastSample(lastSample), .frameOk(frameOk), .strb(strb),
    .loadMode(loadMode), .parLoad(parLoad), .locked(locked)
  );

  autobaud_datapath #(.SLOW_BIT(SLOW_BIT), .DIVW(DIVW)) u_dp (
    .clk(clk), .clr(!rstHold), .rxIn(rxIn), .strb(strb),
    .rxLow(rxLow), .rxFell(rxFell), .hitAny(hitAny), .lastSample(lastSample),
    .frameOk(frameOk), .rateReg(rateReg), .divReg(divReg)
  );

  assign rateCode = locked ? rateReg : 2'd0;
  assign divisor  = locked ? divReg  : '0;

endmodule

// File: rtl/bootbaud_checker.sv
module bootbaud_checker #(
  parameter int unsigned SLOW_BIT = 36864,
  parameter int unsigned DIVW     = $clog2(SLOW_BIT + 1)
) (
  input logic            clk,
  input logic            rstHold,
  input logic            psenN,
  input logic [1:0]      selHi,
  input logic            loadPulse,
  input logic            loadMode,
  input logic            parLoad,
  input logic            locked,
  input logic [1:0]      rateCode,
  input logic [DIVW-1:0] divisor
);

  logic [DIVW-1:0] expDiv;
  always_comb begin
    case (rateCode)
      2'd0:    expDiv = DIVW'(SLOW_BIT);
      2'd1:    expDiv = DIVW'(SLOW_BIT / 4);
      2'd2:    expDiv = DIVW'(SLOW_BIT / 8);
      default: expDiv = DIVW'(SLOW_BIT / 32);
    endcase
  end

  // R1: without the enable pin low, idle is kept
  a_r1_no_entry: assert property (@(posedge clk) disable iff (!rstHold)
    (!loadMode && psenN) |=> !loadMode);

  // R2: reset release clears every flag by the next clock
  a_r2_release: assert property (@(posedge clk)
    !rstHold |=> (!loadMode && !parLoad && !locked));

  // R3: the two paths are mutually exclusive
  a_r3_exclusive: assert property (@(posedge clk) disable iff (!rstHold)
    !(parLoad && locked));

  // R4: strobe ignored while serial path is selected
  a_r4_pulse_ignored: assert property (@(posedge clk) disable iff (!rstHold)
    (loadPulse && selHi == 2'b11 && !parLoad) |=> !parLoad);

  // R8: divisor matches the reported rate
  a_r8_div_match: assert property (@(posedge clk) disable iff (!rstHold)
    locked |-> (divisor == expDiv));

  // R8: lock and its values hold while reset stays high
  a_r8_hold: assert property (@(posedge clk) disable iff (!rstHold)
    locked |=> (locked && $stable(rateCode) && $stable(divisor)));

  // R9: no rate reported without lock
  a_r9_zero: assert property (@(posedge clk) disable iff (!rstHold)
    (!locked && psenN && !loadPulse) |-> (rateCode == 2'd0 && divisor == '0));

endmodule

bind bootbaud_top bootbaud_checker #(.SLOW_BIT(SLOW_BIT), .DIVW(DIVW)) u_chk (
  .clk(clk), .rstHold(rstHold), .psenN(psenN), .selHi(selHi),
  .loadPulse(loadPulse), .loadMode(loadMode), .parLoad(parLoad),
  .locked(locked), .rateCode(rateCode), .divisor(divisor)
);

// File: tb/sim_bootbaud_top.sv
module sim_bootbaud_top;

  localparam int unsigned SLOW = 320;
  localparam int unsigned DW   = $clog2(SLOW + 1);

  logic          clk = 1'b0;
  logic          rstHold = 1'b0, psenN = 1'b1, loadPulse = 1'b0, rxIn = 1'b1;
  logic [1:0]    selHi = 2'b11;
  logic          loadMode, parLoad, locked;
  logic [1:0]    rateCode;
  logic [DW-1:0] divisor;

  int nChk = 0, nBad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  bootbaud_top #(.SLOW_BIT(SLOW)) u0 (
    .clk(clk), .rstHold(rstHold), .psenN(psenN), .selHi(selHi),
    .loadPulse(loadPulse), .rxIn(rxIn), .loadMode(loadMode), .parLoad(parLoad),
    .locked(locked), .rateCode(rateCode), .divisor(divisor)
  );

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, int act, int exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int lenOf(int code);
    case (code)
      0: return SLOW;
      1: return SLOW / 4;
      2: return SLOW / 8;
      default: return SLOW / 32;
    endcase
  endfunction

  task automatic enter(logic [1:0] sel);
    rstHold = 0; psenN = 1; rxIn = 1; loadPulse = 0;
    tick(4);
    rstHold = 1; psenN = 0; selHi = sel;
    tick(1);
    psenN = 1;
    tick(3);
  endtask

  // start width sw, data/stop bits of len clocks; optional strobe on the start edge
  task automatic sendFrame(logic [7:0] b, int sw, int len, logic stopV, bit pulse);
    rxIn = 0;
    loadPulse = pulse;
    tick(1);
    loadPulse = 0;
    tick(sw - 1);
    for (int i = 0; i < 8; i++) begin
      rxIn = b[i];
      tick(len);
    end
    rxIn = stopV;
    tick(len);
    rxIn = 1;
    tick(2 * len + 8);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog R1..: actual=timeout expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    tick(5);
    // Reset state (R2, R9)
    check("R2 reset loadMode", loadMode, 0);
    check("R2 reset locked", locked, 0);
    check("R2 reset parLoad", parLoad, 0);
    check("R9 reset rateCode", rateCode, 0);
    check("R9 reset divisor", divisor, 0);

    // R1: entry needs both pins together
    rstHold = 1; psenN = 1; tick(3);
    check("R1 reset alone", loadMode, 0);
    rstHold = 0; psenN = 0; tick(3);
    check("R1 enable alone", loadMode, 0);
    rstHold = 1; psenN = 0; tick(1);
    check("R1 both pins", loadMode, 1);
    psenN = 1; tick(2);
    check("R1 mode held", loadMode, 1);

    // R5/R6/R8/R9: window sweep over every rate
    for (int c = 0; c < 4; c++) begin
      int pct[5] = '{85, 92, 100, 108, 115};
      for (int k = 0; k < 5; k++) begin
        int len = lenOf(c);
        int w = len * pct[k] / 100;
        int hit = (w >= len - len / 10) && (w <= len + len / 10);
        enter(2'b11);
        sendFrame(8'h0D, w, len, 1'b1, 1'b0);
        check($sformatf("R5 lock code%0d w%0d", c, w), locked, hit);
        check($sformatf("R8 code c%0d w%0d", c, w), rateCode, hit ? c : 0);
        check($sformatf("R9 divisor c%0d w%0d", c, w), divisor, hit ? len : 0);
        if (!hit) begin
          check($sformatf("R6 still waiting c%0d", c), loadMode, 1);
          sendFrame(8'h0D, len, len, 1'b1, 1'b0);
          check($sformatf("R6 recovery c%0d", c), locked, 1);
        end
      end
    end

    // R7: wrong byte, bad stop, then good character
    enter(2'b11);
    sendFrame(8'h0F, 40, 40, 1'b1, 1'b0);
    check("R7 byte 0x0F", locked, 0);
    sendFrame(8'h0D, 40, 40, 1'b0, 1'b0);
    check("R7 stop low", locked, 0);
    check("R9 stop low rate", rateCode, 0);
    sendFrame(8'h0D, 40, 40, 1'b1, 1'b0);
    check("R7 good after bad", locked, 1);
    check("R7 code", rateCode, 2);

    // R8: later characters and strobes do not move the lock
    sendFrame(8'h0D, SLOW, SLOW, 1'b1, 1'b0);
    check("R8 code held", rateCode, 2);
    check("R8 divisor held", divisor, 40);
    selHi = 2'b00; loadPulse = 1; tick(1); loadPulse = 0; tick(2);
    check("R8 pulse after lock", parLoad, 0);
    check("R8 lock kept", locked, 1);

    // R2: release while locked
    rstHold = 0; tick(1);
    check("R2 release locked", locked, 0);
    check("R2 release mode", loadMode, 0);
    check("R2 release divisor", divisor, 0);

    // R4: strobe with serial selection
    enter(2'b11);
    loadPulse = 1; tick(1); loadPulse = 0; tick(2);
    check("R4 pulse ignored", parLoad, 0);

    // R3: every parallel selection
    for (int s = 0; s < 3; s++) begin
      enter(2'(s));
      sendFrame(8'h0D, 10, 10, 1'b1, 1'b0);
      check($sformatf("R3 serial ignored sel%0d", s), locked, 0);
      loadPulse = 1; tick(1); loadPulse = 0;
      check($sformatf("R3 parLoad sel%0d", s), parLoad, 1);
    end

    // Same-cycle strobe and start edge
    enter(2'b11);
    sendFrame(8'h0D, 80, 80, 1'b1, 1'b1);
    check("R4 concurrent serial lock", locked, 1);
    check("R4 concurrent no parLoad", parLoad, 0);
    enter(2'b01);
    sendFrame(8'h0D, 80, 80, 1'b1, 1'b1);
    check("R3 concurrent parLoad", parLoad, 1);
    check("R3 concurrent no lock", locked, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

endmodule